// File: doc/BRIEF.md
# Orthogonal Variable Spreading Factor Code Tree Allocator

This block tracks which channelization codes of one cell are in use. The codes form a binary tree up to depth 9 (spreading factor 512). It decides whether a requested code can be handed out without breaking orthogonality. Two codes are orthogonal exactly when neither one lies on the path from the other to the root. A code of spreading factor `2^d` and index `k` has the children `(2^(d+1), 2k)` and `(2^(d+1), 2k+1)`. The block stores one occupancy bit for each node of the tree.

A request carries an operation (allocate, release or query), the spreading-factor exponent `d` and the index `k`. It is accepted when `req_valid_i` is high while `busy_o` is low. The block then walks the tree one level per clock, from the root down to the deepest level. At each level it tests one node for a level above `d`, the requested node for level `d`, and the contiguous range of indices under `k` for a level below `d`. When the walk is over, `done_o` pulses together with a status code. In the same cycle the block sets or clears the node's bit if the operation succeeded. The latency depends only on the maximum depth. Choosing a free code is left to the caller.

Top module: `ovsf_tree_alloc`

## Requirements
- R1: After reset every node is free, and `busy_o` and `done_o` are low.
- R2: A request is accepted at a rising edge where `req_valid_i` is high and `busy_o` is low. `done_o` is high for exactly one cycle, in the MAX_DEPTH+2-th cycle after acceptance (cycle 11 by default), whatever the operation and arguments. `req_valid_i` has no effect while `busy_o` is high.
- R3: Allocate (op 0) of a free code with no occupied ancestor or descendant returns status 0 (grant) and marks the code occupied.
- R4: Allocate returns status 1 (deny) and changes nothing if any ancestor at depth `d' < d` is occupied. That ancestor is index `k >> (d - d')`.
- R5: Allocate returns status 1 (deny) and changes nothing if any descendant is occupied. At depth `d'' > d` the descendants are the indices `k*2^(d''-d)` to `(k+1)*2^(d''-d)-1`.
- R6: Allocate of a code that is already occupied returns status 2 (mismatch) and changes nothing. This status takes priority over deny.
- R7: Release (op 1) of an occupied code returns status 0 and frees it. Release of a free code returns status 2 and changes nothing.
- R8: Query (op 2) returns the status that allocate would return, and never changes the occupancy.
- R9: Op 3, an exponent outside 2..MAX_DEPTH, or an index not below `2^d` returns status 3 (invalid) and changes nothing.
- R10: `clear_i` frees every node at the next edge and abandons any request in progress, so no `done_o` is given for that request.
- R11: No occupied node ever has an occupied ancestor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous free-all |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 2 | 0 allocate, 1 release, 2 query, 3 reserved |
| req_sf_exp_i | input | 4 | Spreading-factor exponent d (SF = 2^d) |
| req_idx_i | input | 9 | Code index k |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 0 grant, 1 deny, 2 mismatch, 3 invalid; valid with done_o |

## Verification
Some properties are checked on every cycle by assertions. No occupied node ever has an occupied ancestor anywhere in the tree. `done_o` is a single-cycle pulse at the fixed latency. The occupancy changes only on a commit or a clear, and is empty right after a clear. Other behaviour can only be shown by the bench scenarios. These cover the choice between grant, deny, mismatch and invalid for particular ancestor and descendant layouts, and requests ignored while busy. They also cover a clear that aborts a walk, and a query leaving the tree untouched, which the bench shows by allocating afterwards.

// File: rtl/ovsf_alloc_pkg.sv
package ovsf_alloc_pkg;
  typedef enum logic [1:0] {
    OP_ALLOC   = 2'd0,
    OP_RELEASE = 2'd1,
    OP_QUERY   = 2'd2,
    OP_RSVD    = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_GRANT    = 2'd0,
    ST_DENY     = 2'd1,
    ST_MISMATCH = 2'd2,
    ST_INVALID  = 2'd3
  } status_e;

  typedef enum logic [1:0] {
    FSM_IDLE = 2'd0,
    FSM_WALK = 2'd1,
    FSM_DONE = 2'd2
  } fsm_e;
endpackage

// File: rtl/ovsf_occ_store.sv
module ovsf_occ_store #(
  parameter int MAX_DEPTH = 9,
  localparam int DEP_W    = $clog2(MAX_DEPTH + 1),
  localparam int IDX_W    = MAX_DEPTH,
  localparam int LEAVES   = 1 << MAX_DEPTH,
  localparam int NODES    = (1 << (MAX_DEPTH + 1)) - 1,
  localparam int NODE_W   = $clog2(NODES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic              wr_set_i,
  input  logic [DEP_W-1:0]  wr_lvl_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DEP_W-1:0]  rd_lvl_i,
  output logic [LEAVES-1:0] rd_vec_o
);
  // heap layout: node(L, i) = 2^L - 1 + i
  logic [NODES-1:0]  occ_q;
  logic [NODE_W-1:0] wr_node;
  logic [LEAVES-1:0] lvl_vec [MAX_DEPTH+1];

  assign wr_node = ((NODE_W'(1) << wr_lvl_i) - NODE_W'(1)) + NODE_W'(wr_idx_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      occ_q <= '0;
    else if (clr_i)   occ_q <= '0;
    else if (wr_en_i) occ_q[wr_node] <= wr_set_i;
  end

  for (genvar L = 0; L <= MAX_DEPTH; L++) begin : g_lv
    logic [LEAVES-1:0] occ;
    logic [LEAVES-1:0] anc;

    always_comb begin
      occ = '0;
      for (int i = 0; i < (1 << L); i++) occ[i] = occ_q[(1 << L) - 1 + i];
    end

    if (L == 0) begin : g_root
      assign anc = '0;
    end else begin : g_sub
      always_comb begin
        anc = '0;
        for (int i = 0; i < (1 << L); i++)
          anc[i] = g_lv[L-1].occ[i/2] | g_lv[L-1].anc[i/2];
      end
    end

    assign lvl_vec[L] = occ;

    // R11
    orth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (occ & anc) == '0);
  end

  always_comb begin
    rd_vec_o = '0;
    if (int'(rd_lvl_i) <= MAX_DEPTH) rd_vec_o = lvl_vec[rd_lvl_i];
  end

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !clr_i) |=> $stable(occ_q));

  // R10
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (occ_q == '0));
endmodule

// File: rtl/ovsf_level_probe.sv
module ovsf_level_probe #(
  parameter int MAX_DEPTH = 9,
  localparam int DEP_W    = $clog2(MAX_DEPTH + 1),
  localparam int IDX_W    = MAX_DEPTH,
  localparam int LEAVES   = 1 << MAX_DEPTH
) (
  input  logic [DEP_W-1:0]  lvl_i,
  input  logic [DEP_W-1:0]  dep_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [LEAVES-1:0] vec_i,
  output logic              anc_o,
  output logic              self_o,
  output logic              desc_o
);
  always_comb begin
    anc_o  = 1'b0;
    self_o = 1'b0;
    desc_o = 1'b0;
    if (lvl_i < dep_i) begin
      anc_o = vec_i[idx_i >> (dep_i - lvl_i)];
    end else if (lvl_i == dep_i) begin
      self_o = vec_i[idx_i];
    end else begin
      // subtree of k at this level: indices whose prefix equals k
      for (int i = 0; i < LEAVES; i++)
        if ((IDX_W'(i) >> (lvl_i - dep_i)) == idx_i) desc_o = desc_o | vec_i[i];
    end
  end
endmodule

// File: rtl/ovsf_walk_ctrl.sv
module ovsf_walk_ctrl
  import ovsf_alloc_pkg::*;
#(
  parameter int MAX_DEPTH = 9,
  parameter int MIN_DEPTH = 2,
  localparam int DEP_W    = $clog2(MAX_DEPTH + 1),
  localparam int IDX_W    = MAX_DEPTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             req_valid_i,
  input  logic [1:0]       req_op_i,
  input  logic [DEP_W-1:0] req_dep_i,
  input  logic [IDX_W-1:0] req_idx_i,
  input  logic             anc_i,
  input  logic             self_i,
  input  logic             desc_i,
  output logic [DEP_W-1:0] lvl_o,
  output logic [DEP_W-1:0] dep_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             wr_en_o,
  output logic             wr_set_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       status_o
);
  localparam logic [DEP_W-1:0] LAST_LVL = DEP_W'(MAX_DEPTH);
  localparam int               CNT_W    = DEP_W + 1;

  fsm_e             state_q;
  op_e              op_q;
  logic [DEP_W-1:0] dep_q, lvl_q;
  logic [IDX_W-1:0] idx_q;
  logic             bad_q, anc_q, self_q, desc_q;
  logic             req_bad;
  status_e          status;

  assign req_bad = (req_op_i == OP_RSVD)
                || (int'(req_dep_i) < MIN_DEPTH)
                || (int'(req_dep_i) > MAX_DEPTH)
                || ((32'(req_idx_i) >> req_dep_i) != 0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FSM_IDLE;
      op_q    <= OP_ALLOC;
      dep_q   <= '0;
      idx_q   <= '0;
      lvl_q   <= '0;
      bad_q   <= 1'b0;
      anc_q   <= 1'b0;
      self_q  <= 1'b0;
      desc_q  <= 1'b0;
    end else if (clear_i) begin
      state_q <= FSM_IDLE;
    end else begin
      unique case (state_q)
        FSM_IDLE: if (req_valid_i) begin
          state_q <= FSM_WALK;
          op_q    <= op_e'(req_op_i);
          dep_q   <= req_dep_i;
          idx_q   <= req_idx_i;
          bad_q   <= req_bad;
          lvl_q   <= '0;
          anc_q   <= 1'b0;
          self_q  <= 1'b0;
          desc_q  <= 1'b0;
        end
        FSM_WALK: begin
          anc_q  <= anc_q | anc_i;
          self_q <= self_q | self_i;
          desc_q <= desc_q | desc_i;
          lvl_q  <= lvl_q + DEP_W'(1);
          if (lvl_q == LAST_LVL) state_q <= FSM_DONE;
        end
        FSM_DONE: state_q <= FSM_IDLE;
        default:  state_q <= FSM_IDLE;
      endcase
    end
  end

  always_comb begin
    if (bad_q) status = ST_INVALID;
    else if (op_q == OP_RELEASE) status = self_q ? ST_GRANT : ST_MISMATCH;
    else if (self_q) status = ST_MISMATCH;
    else if (anc_q || desc_q) status = ST_DENY;
    else status = ST_GRANT;
  end

  assign lvl_o    = lvl_q;
  assign dep_o    = dep_q;
  assign idx_o    = idx_q;
  assign busy_o   = (state_q != FSM_IDLE);
  assign done_o   = (state_q == FSM_DONE);
  assign status_o = status;
  assign wr_set_o = (op_q == OP_ALLOC);
  assign wr_en_o  = done_o && (status == ST_GRANT)
                 && ((op_q == OP_ALLOC) || (op_q == OP_RELEASE));

  // cycles since acceptance, for the latency check
  logic [CNT_W-1:0] lat_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      lat_q <= '0;
    else if (!busy_o)                 lat_q <= '0;
    else if (lat_q != {CNT_W{1'b1}})  lat_q <= lat_q + CNT_W'(1);
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R2
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (int'(lat_q) == MAX_DEPTH + 1));

  // R9
  bad_nowrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && bad_q) |-> !wr_en_o);
endmodule

// File: rtl/ovsf_tree_alloc.sv
module ovsf_tree_alloc #(
  parameter int MAX_DEPTH = 9,
  parameter int MIN_DEPTH = 2,
  localparam int DEP_W    = $clog2(MAX_DEPTH + 1),
  localparam int IDX_W    = MAX_DEPTH,
  localparam int LEAVES   = 1 << MAX_DEPTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             req_valid_i,
  input  logic [1:0]       req_op_i,
  input  logic [DEP_W-1:0] req_sf_exp_i,
  input  logic [IDX_W-1:0] req_idx_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       status_o
);
  logic [DEP_W-1:0]  lvl, dep;
  logic [IDX_W-1:0]  idx;
  logic [LEAVES-1:0] vec;
  logic              anc_hit, self_hit, desc_hit, wr_en, wr_set;

  ovsf_walk_ctrl #(.MAX_DEPTH(MAX_DEPTH), .MIN_DEPTH(MIN_DEPTH)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear_i),
    .req_valid_i (req_valid_i),
    .req_op_i    (req_op_i),
    .req_dep_i   (req_sf_exp_i),
    .req_idx_i   (req_idx_i),
    .anc_i       (anc_hit),
    .self_i      (self_hit),
    .desc_i      (desc_hit),
    .lvl_o       (lvl),
    .dep_o       (dep),
    .idx_o       (idx),
    .wr_en_o     (wr_en),
    .wr_set_o    (wr_set),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .status_o    (status_o)
  );

  ovsf_occ_store #(.MAX_DEPTH(MAX_DEPTH)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clear_i),
    .wr_en_i  (wr_en),
    .wr_set_i (wr_set),
    .wr_lvl_i (dep),
    .wr_idx_i (idx),
    .rd_lvl_i (lvl),
    .rd_vec_o (vec)
  );

  ovsf_level_probe #(.MAX_DEPTH(MAX_DEPTH)) u_probe (
    .lvl_i  (lvl),
    .dep_i  (dep),
    .idx_i  (idx),
    .vec_i  (vec),
    .anc_o  (anc_hit),
    .self_o (self_hit),
    .desc_o (desc_hit)
  );

  // R1
  idle_after_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
endmodule

// File: tb/ovsf_tree_alloc_test.sv
module ovsf_tree_alloc_test;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 11;

  localparam logic [1:0] A = 2'd0, R = 2'd1, Q = 2'd2, X = 2'd3;
  localparam logic [1:0] GR = 2'd0, DN = 2'd1, MM = 2'd2, IV = 2'd3;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clear_i = 1'b0;
  logic       req_valid_i = 1'b0;
  logic [1:0] req_op_i = '0;
  logic [3:0] req_sf_exp_i = '0;
  logic [8:0] req_idx_i = '0;
  logic       busy_o, done_o;
  logic [1:0] status_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  ovsf_tree_alloc uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i),
    .req_valid_i(req_valid_i), .req_op_i(req_op_i),
    .req_sf_exp_i(req_sf_exp_i), .req_idx_i(req_idx_i),
    .busy_o(busy_o), .done_o(done_o), .status_o(status_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input int e, input int k);
    req_valid_i  = 1'b1;
    req_op_i     = op;
    req_sf_exp_i = 4'(e);
    req_idx_i    = 9'(k);
  endtask

  // waits for done after the accept edge; returns cycles counted from acceptance
  task automatic wait_done(output int lat);
    lat = 1;
    while (!done_o && lat < 40) begin
      @(negedge clk_i);
      lat++;
    end
  endtask

  task automatic do_op(input logic [1:0] op, input int e, input int k,
                       input logic [1:0] exp_st, input string tag);
    int lat;
    @(negedge clk_i);
    drive(op, e, k);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    wait_done(lat);
    chk(lat == LAT, "R2 latency", lat, LAT);
    chk(status_o == exp_st, tag, int'(status_o), int'(exp_st));
    @(negedge clk_i);
    chk(!done_o, "R2 single pulse", int'(done_o), 0);
  endtask

  task automatic t_reset;
    chk(!busy_o, "R1 busy after reset", int'(busy_o), 0);
    chk(!done_o, "R1 done after reset", int'(done_o), 0);
    do_op(Q, 2, 0, GR, "R1 query (4,0) free");
    do_op(Q, 9, 511, GR, "R1 query (512,511) free");
  endtask

  task automatic t_grant;
    do_op(A, 2, 1, GR, "R3 alloc (4,1)");
    do_op(Q, 2, 1, MM, "R3 (4,1) now held");
  endtask

  task automatic t_ancestor;
    do_op(A, 3, 2, DN, "R4 alloc (8,2) under (4,1)");
    do_op(A, 9, 200, DN, "R4 alloc (512,200) under (4,1)");
  endtask

  task automatic t_descendant;
    do_op(A, 9, 127, GR, "R5 alloc (512,127)");
    do_op(A, 2, 0, DN, "R5 alloc (4,0) over (512,127)");
    do_op(A, 3, 1, DN, "R5 alloc (8,1) over (512,127)");
    do_op(A, 3, 0, GR, "R5 alloc (8,0) sibling subtree");
  endtask

  task automatic t_held;
    do_op(A, 2, 1, MM, "R6 realloc (4,1)");
    do_op(Q, 3, 3, DN, "R6 (4,1) still held");
  endtask

  task automatic t_release;
    do_op(R, 9, 127, GR, "R7 release (512,127)");
    do_op(R, 9, 127, MM, "R7 second release (512,127)");
    do_op(A, 3, 1, GR, "R7 alloc (8,1) after release");
    do_op(R, 2, 0, MM, "R7 release never-held (4,0)");
  endtask

  task automatic t_query;
    do_op(Q, 2, 0, DN, "R8 query (4,0) over held children");
    do_op(Q, 2, 2, GR, "R8 query (4,2) free");
    do_op(A, 3, 4, GR, "R8 (4,2) not taken by query");
    do_op(Q, 2, 1, MM, "R8 query held (4,1)");
  endtask

  task automatic t_invalid;
    do_op(X, 2, 3, IV, "R9 reserved op");
    do_op(A, 1, 0, IV, "R9 exponent 1");
    do_op(A, 10, 0, IV, "R9 exponent 10");
    do_op(A, 2, 4, IV, "R9 index out of range");
    do_op(Q, 2, 3, GR, "R9 state unchanged");
  endtask

  task automatic t_busy_ignore;
    int lat;
    int extra;
    @(negedge clk_i);
    drive(A, 2, 3);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    repeat (2) @(negedge clk_i);
    drive(R, 2, 1);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    lat = 4;
    while (!done_o && lat < 40) begin
      @(negedge clk_i);
      lat++;
    end
    chk(lat == LAT, "R2 latency with busy strobe", lat, LAT);
    chk(status_o == GR, "R2 first request granted", int'(status_o), int'(GR));
    extra = 0;
    repeat (15) begin
      @(negedge clk_i);
      if (done_o) extra++;
    end
    chk(extra == 0, "R2 strobe while busy ignored", extra, 0);
    do_op(Q, 2, 1, MM, "R2 (4,1) not released");
  endtask

  task automatic t_clear;
    int seen;
    @(negedge clk_i);
    drive(A, 9, 0);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
    clear_i = 1'b1;
    @(negedge clk_i);
    clear_i = 1'b0;
    chk(!busy_o, "R10 clear aborts walk", int'(busy_o), 0);
    seen = 0;
    repeat (15) begin
      @(negedge clk_i);
      if (done_o) seen++;
    end
    chk(seen == 0, "R10 no done after clear", seen, 0);
    do_op(A, 2, 1, GR, "R10 (4,1) freed");
    do_op(A, 2, 0, GR, "R10 (4,0) subtree freed");
    do_op(Q, 9, 0, DN, "R10 aborted alloc left no trace");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_grant();
    t_ancestor();
    t_descendant();
    t_held();
    t_release();
    t_query();
    t_invalid();
    t_busy_ignore();
    t_clear();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule